// File: doc/BRIEF.md
# Banked Unified Scalar/Vector Register File

This block holds 64 words of 32 bits that the surrounding datapath can treat either as 64 separate scalar registers or as eight short vector registers of eight elements. The storage is split into eight banks of eight entries. A location is named by a 6-bit address whose upper three bits select the bank and whose lower three bits select the entry index inside that bank.

Each cycle the file serves two operand groups, called RS and RT, of four 32-bit lanes each. It also accepts up to four 32-bit writes, and each write lane has its own enable. Every port group has a vector flag. When the flag is low, each lane uses its own address, so four independent scalar operations can issue side by side. When the flag is high, only lane 0's address counts. Lane k then accesses element k of the vector, which lies in the same bank at index (start + k) mod 8. A vector may therefore begin at any index and wrap round inside its bank. A longer vector is covered by issuing again with the start index advanced by four.

Reads are combinational, and a write presented in the same cycle is forwarded to any read of the same address. The storage clears to zero on reset.

Top module: `banked_rf`

## Requirements
- R1: After reset every one of the 64 locations reads as zero.
- R2: A 6-bit address is {bank[5:3], index[2:0]}, and location number a equals bank*8 + index. With the vector flag low, read lane k returns the word at lane k's own address, on both the RS and the RT groups.
- R3: With the vector flag high, read lane k returns the word at bank = lane-0 bank and index = (lane-0 index + k) mod 8. This holds for every start index from 0 to 7, so the element index wraps from 7 to 0.
- R4: A write lane stores its data at its effective address on the rising clock edge only when its enable bit is set. A lane whose enable is clear changes no location.
- R5: With the write vector flag high, write lane k targets bank = lane-0 bank and index = (lane-0 index + k) mod 8, still gated by its own enable.
- R6: When several enabled write lanes target the same address in one cycle, the highest-numbered lane's data is the value stored.
- R7: A read whose address matches an enabled write in the same cycle returns the data being written, taken from the highest-numbered matching lane. This applies in the same cycle, before the clock edge.
- R8: With a vector flag high, the addresses on lanes 1 to 3 of that port group have no effect on which words are read or written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; clears all storage |
| rs_vec | input | 1 | RS group vector flag (1 = lanes follow lane 0 start) |
| rs_addr | input | 24 | RS lane addresses, lane k at bits [6k+5:6k] |
| rs_data | output | 128 | RS lane read data, lane k at bits [32k+31:32k] |
| rt_vec | input | 1 | RT group vector flag |
| rt_addr | input | 24 | RT lane addresses, lane k at bits [6k+5:6k] |
| rt_data | output | 128 | RT lane read data, lane k at bits [32k+31:32k] |
| wr_vec | input | 1 | Write group vector flag |
| wr_en | input | 4 | Per-lane write enables, bit k for lane k |
| wr_addr | input | 24 | Write lane addresses, lane k at bits [6k+5:6k] |
| wr_data | input | 128 | Write lane data, lane k at bits [32k+31:32k] |

## Verification
The bench builds the block with its default parameters: eight banks of eight 32-bit entries and four lanes per group. That configuration is small enough to visit every one of the 64 addresses through both read groups. It also allows every bank and start-index pair to be tried as a vector read and as a vector write, and all sixteen write-enable masks to be applied. The same setting covers the wrap from index 7 to 0, write collisions and same-cycle forwarding, each at a handful of chosen addresses.

// File: rtl/rf_pkg.sv
package rf_pkg;
    // Access mode of one port group.
    typedef enum logic {
        ACC_SCALAR = 1'b0,
        ACC_VECTOR = 1'b1
    } acc_mode_e;
endpackage

// File: rtl/rf_addr_gen.sv
// Turns the raw lane addresses of one port group into effective lane
// addresses. In vector mode every lane is derived from lane 0's start.
module rf_addr_gen
    import rf_pkg::*;
#(
    parameter  int LANES  = 4,
    parameter  int DEPTH  = 8,
    parameter  int IDX_W  = 3,
    parameter  int ADDR_W = 6
) (
    input  acc_mode_e                 mode,
    input  logic [LANES*ADDR_W-1:0]   addr_in,
    output logic [LANES*ADDR_W-1:0]   addr_out
);
    localparam int BANK_W = ADDR_W - IDX_W;

    logic [BANK_W-1:0] base_bank;
    logic [IDX_W-1:0]  base_idx;

    assign base_bank = addr_in[IDX_W +: BANK_W];
    assign base_idx  = addr_in[0 +: IDX_W];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [IDX_W:0]   idx_sum;
        logic [IDX_W-1:0] idx_wrap;

        always_comb begin
            idx_sum = {1'b0, base_idx} + (IDX_W+1)'(k);
            if (idx_sum >= (IDX_W+1)'(DEPTH))
                idx_wrap = IDX_W'(idx_sum - (IDX_W+1)'(DEPTH));
            else
                idx_wrap = idx_sum[IDX_W-1:0];
        end

        assign addr_out[k*ADDR_W +: ADDR_W] = (mode == ACC_VECTOR)
                                            ? {base_bank, idx_wrap}
                                            : addr_in[k*ADDR_W +: ADDR_W];
    end
endmodule

// File: rtl/rf_bank.sv
// One bank of the register file. Lanes are applied in ascending order so
// that the highest-numbered matching lane is the one that lands.
module rf_bank #(
    parameter  int DATA_W  = 32,
    parameter  int DEPTH   = 8,
    parameter  int LANES   = 4,
    parameter  int IDX_W   = 3,
    parameter  int ADDR_W  = 6,
    parameter  int BANK_ID = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          wr_en,
    input  logic [LANES*ADDR_W-1:0]   wr_addr,
    input  logic [LANES*DATA_W-1:0]   wr_data,
    output logic [DEPTH*DATA_W-1:0]   words
);
    localparam int BANK_W = ADDR_W - IDX_W;

    logic [DATA_W-1:0] entry_q [DEPTH];
    logic [LANES-1:0]  lane_hit;

    for (genvar l = 0; l < LANES; l++) begin : g_hit
        assign lane_hit[l] = wr_en[l] &&
            (wr_addr[l*ADDR_W+IDX_W +: BANK_W] == BANK_W'(BANK_ID));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) entry_q[e] <= '0;
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (lane_hit[l] && (wr_addr[l*ADDR_W +: IDX_W] == IDX_W'(e)))
                        entry_q[e] <= wr_data[l*DATA_W +: DATA_W];
                end
            end
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_out
        assign words[e*DATA_W +: DATA_W] = entry_q[e];
    end
endmodule

// File: rtl/rf_read_port.sv
// One read group: selects stored words and forwards same-cycle writes.
module rf_read_port #(
    parameter  int DATA_W = 32,
    parameter  int WORDS  = 64,
    parameter  int LANES  = 4,
    parameter  int ADDR_W = 6
) (
    input  logic [LANES*ADDR_W-1:0]  rd_addr,
    input  logic [WORDS*DATA_W-1:0]  words,
    input  logic [LANES-1:0]         wr_en,
    input  logic [LANES*ADDR_W-1:0]  wr_addr,
    input  logic [LANES*DATA_W-1:0]  wr_data,
    output logic [LANES*DATA_W-1:0]  rd_data
);
    for (genvar r = 0; r < LANES; r++) begin : g_rd
        logic [ADDR_W-1:0] ra;
        logic [DATA_W-1:0] val;

        assign ra = rd_addr[r*ADDR_W +: ADDR_W];

        always_comb begin
            val = words[int'(ra)*DATA_W +: DATA_W];
            for (int l = 0; l < LANES; l++) begin
                if (wr_en[l] && (wr_addr[l*ADDR_W +: ADDR_W] == ra))
                    val = wr_data[l*DATA_W +: DATA_W];
            end
        end

        assign rd_data[r*DATA_W +: DATA_W] = val;
    end
endmodule

// File: rtl/banked_rf.sv
module banked_rf
    import rf_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int BANKS  = 8,
    parameter  int DEPTH  = 8,
    parameter  int LANES  = 4,
    localparam int BANK_W = $clog2(BANKS),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int ADDR_W = BANK_W + IDX_W,
    localparam int WORDS  = BANKS * DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rs_vec,
    input  logic [LANES*ADDR_W-1:0]  rs_addr,
    output logic [LANES*DATA_W-1:0]  rs_data,
    input  logic                     rt_vec,
    input  logic [LANES*ADDR_W-1:0]  rt_addr,
    output logic [LANES*DATA_W-1:0]  rt_data,
    input  logic                     wr_vec,
    input  logic [LANES-1:0]         wr_en,
    input  logic [LANES*ADDR_W-1:0]  wr_addr,
    input  logic [LANES*DATA_W-1:0]  wr_data
);
    logic [LANES*ADDR_W-1:0] rs_eff, rt_eff, wr_eff;
    logic [WORDS*DATA_W-1:0] bank_words;

    rf_addr_gen #(.LANES(LANES), .DEPTH(DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W))
        u_rs_addr (.mode(acc_mode_e'(rs_vec)), .addr_in(rs_addr), .addr_out(rs_eff));
    rf_addr_gen #(.LANES(LANES), .DEPTH(DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W))
        u_rt_addr (.mode(acc_mode_e'(rt_vec)), .addr_in(rt_addr), .addr_out(rt_eff));
    rf_addr_gen #(.LANES(LANES), .DEPTH(DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W))
        u_wr_addr (.mode(acc_mode_e'(wr_vec)), .addr_in(wr_addr), .addr_out(wr_eff));

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        rf_bank #(
            .DATA_W(DATA_W), .DEPTH(DEPTH), .LANES(LANES),
            .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BANK_ID(b)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en),
            .wr_addr(wr_eff),
            .wr_data(wr_data),
            .words  (bank_words[b*DEPTH*DATA_W +: DEPTH*DATA_W])
        );
    end

    rf_read_port #(.DATA_W(DATA_W), .WORDS(WORDS), .LANES(LANES), .ADDR_W(ADDR_W))
        u_rs_port (.rd_addr(rs_eff), .words(bank_words), .wr_en(wr_en),
                   .wr_addr(wr_eff), .wr_data(wr_data), .rd_data(rs_data));
    rf_read_port #(.DATA_W(DATA_W), .WORDS(WORDS), .LANES(LANES), .ADDR_W(ADDR_W))
        u_rt_port (.rd_addr(rt_eff), .words(bank_words), .wr_en(wr_en),
                   .wr_addr(wr_eff), .wr_data(wr_data), .rd_data(rt_data));
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 64,
    parameter int LANES  = 4,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rs_vec,
    input logic [ADDR_W-1:0]       rs_addr0,
    input logic [DATA_W-1:0]       rs_data0,
    input logic [DATA_W-1:0]       rs_data1,
    input logic                    wr_vec,
    input logic [LANES-1:0]        wr_en,
    input logic [ADDR_W-1:0]       wr_addr0,
    input logic [ADDR_W-1:0]       wr_addr_top,
    input logic [DATA_W-1:0]       wr_data_top,
    input logic [WORDS*DATA_W-1:0] mem_flat
);
    logic [ADDR_W-1:0] last_addr_q;
    logic [DATA_W-1:0] last_data_q;
    logic [IDX_W-1:0]  next_idx;
    logic [ADDR_W-1:0] lane1_addr;

    always_ff @(posedge clk) begin
        last_addr_q <= wr_addr_top;
        last_data_q <= wr_data_top;
    end

    assign next_idx   = rs_addr0[IDX_W-1:0] + IDX_W'(1);
    assign lane1_addr = {rs_addr0[ADDR_W-1:IDX_W], next_idx};

    // R1
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem_flat == '0));

    // R4
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) |=> $stable(mem_flat));

    // R6
    a_r6_top_lane_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_vec && wr_en[0] && wr_en[LANES-1] && (wr_addr0 == wr_addr_top))
        |=> (mem_flat[int'(last_addr_q)*DATA_W +: DATA_W] == last_data_q));

    // R7
    a_r7_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (!rs_vec && !wr_vec && wr_en[LANES-1] && (rs_addr0 == wr_addr_top))
        |-> (rs_data0 == wr_data_top));

    // R3
    a_r3_vector_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_vec && (wr_en == '0))
        |-> (rs_data1 == mem_flat[int'(lane1_addr)*DATA_W +: DATA_W]));
endmodule

bind banked_rf rf_checker #(
    .DATA_W(DATA_W), .WORDS(WORDS), .LANES(LANES), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_rf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rs_vec     (rs_vec),
    .rs_addr0   (rs_addr[ADDR_W-1:0]),
    .rs_data0   (rs_data[DATA_W-1:0]),
    .rs_data1   (rs_data[2*DATA_W-1:DATA_W]),
    .wr_vec     (wr_vec),
    .wr_en      (wr_en),
    .wr_addr0   (wr_addr[ADDR_W-1:0]),
    .wr_addr_top(wr_addr[LANES*ADDR_W-1 -: ADDR_W]),
    .wr_data_top(wr_data[LANES*DATA_W-1 -: DATA_W]),
    .mem_flat   (bank_words)
);

// File: tb/test_banked_rf.sv
module test_banked_rf;
    localparam int DW = 32;
    localparam int L  = 4;
    localparam int AW = 6;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            rs_vec, rt_vec, wr_vec;
    logic [L*AW-1:0] rs_addr, rt_addr, wr_addr;
    logic [L*DW-1:0] rs_data, rt_data, wr_data;
    logic [L-1:0]    wr_en;

    logic [31:0] model [64];
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    banked_rf i_banked_rf (
        .clk(clk), .rst_n(rst_n),
        .rs_vec(rs_vec), .rs_addr(rs_addr), .rs_data(rs_data),
        .rt_vec(rt_vec), .rt_addr(rt_addr), .rt_data(rt_data),
        .wr_vec(wr_vec), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [31:0] pat(int a, int s);
        return (32'(s) * 32'h0100_0193) ^ (32'(a) * 32'h0001_0001) ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        rs_vec = 0; rt_vec = 0; wr_vec = 0; wr_en = '0;
        rs_addr = '0; rt_addr = '0; wr_addr = '0; wr_data = '0;
    endtask

    // R2: scalar reads of all 64 locations on both groups
    task automatic scalar_sweep(string req);
        for (int g = 0; g < 16; g++) begin
            @(negedge clk);
            idle();
            for (int k = 0; k < L; k++) begin
                rs_addr[k*AW +: AW] = AW'(g*4 + k);
                rt_addr[k*AW +: AW] = AW'(63 - (g*4 + k));
            end
            #1;
            for (int k = 0; k < L; k++) begin
                chk(req, rs_data[k*DW +: DW], model[g*4 + k]);
                chk(req, rt_data[k*DW +: DW], model[63 - (g*4 + k)]);
            end
        end
    endtask

    initial begin
        for (int a = 0; a < 64; a++) model[a] = '0;
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: everything reads zero after reset
        scalar_sweep("R1");

        // R2 / R4: scalar writes to all locations, all lanes enabled
        for (int g = 0; g < 16; g++) begin
            @(negedge clk);
            idle();
            wr_en = '1;
            for (int k = 0; k < L; k++) begin
                wr_addr[k*AW +: AW] = AW'(g*4 + k);
                wr_data[k*DW +: DW] = pat(g*4 + k, 1);
            end
            @(posedge clk);
            for (int k = 0; k < L; k++) model[g*4 + k] = pat(g*4 + k, 1);
        end
        scalar_sweep("R2");

        // R4: every enable mask; disabled lanes leave their location alone
        for (int m = 0; m < 16; m++) begin
            @(negedge clk);
            idle();
            wr_en = 4'(m);
            for (int k = 0; k < L; k++) begin
                wr_addr[k*AW +: AW] = AW'(m*4 + k);
                wr_data[k*DW +: DW] = pat(m*4 + k, 2);
            end
            @(posedge clk);
            for (int k = 0; k < L; k++)
                if (m[k]) model[m*4 + k] = pat(m*4 + k, 2);
            @(negedge clk);
            idle();
            for (int k = 0; k < L; k++) rs_addr[k*AW +: AW] = AW'(m*4 + k);
            #1;
            for (int k = 0; k < L; k++)
                chk("R4", rs_data[k*DW +: DW], model[m*4 + k]);
        end

        // R3 / R8: vector reads from every bank and start index
        for (int b = 0; b < 8; b++) begin
            for (int si = 0; si < 8; si++) begin
                @(negedge clk);
                idle();
                rs_vec = 1; rt_vec = 1;
                for (int k = 0; k < L; k++) begin
                    rs_addr[k*AW +: AW] = AW'((k*13 + b*7 + si) % 64);
                    rt_addr[k*AW +: AW] = AW'((k*29 + si*5 + 3) % 64);
                end
                rs_addr[0 +: AW] = AW'(b*8 + si);
                rt_addr[0 +: AW] = AW'(((b+1)%8)*8 + (si+3)%8);
                #1;
                for (int k = 0; k < L; k++) begin
                    chk("R3", rs_data[k*DW +: DW], model[b*8 + (si+k)%8]);
                    chk("R8", rt_data[k*DW +: DW], model[((b+1)%8)*8 + (si+3+k)%8]);
                end
            end
        end

        // R5 / R7: vector writes from every bank and start, with forwarding
        for (int b = 0; b < 8; b++) begin
            for (int si = 0; si < 8; si++) begin
                @(negedge clk);
                idle();
                wr_vec = 1; wr_en = '1;
                for (int k = 0; k < L; k++) begin
                    wr_addr[k*AW +: AW] = AW'((k*11 + si*3 + b) % 64);
                    wr_data[k*DW +: DW] = pat(b*8 + si, 3 + k);
                end
                wr_addr[0 +: AW] = AW'(b*8 + si);
                rs_addr[0 +: AW] = AW'(b*8 + (si+3)%8);
                #1;
                chk("R7", rs_data[0 +: DW], pat(b*8 + si, 6));
                @(posedge clk);
                for (int k = 0; k < L; k++) model[b*8 + (si+k)%8] = pat(b*8 + si, 3 + k);
            end
        end
        scalar_sweep("R5");

        // R6 / R7: all four lanes hit one address
        @(negedge clk);
        idle();
        wr_en = '1;
        for (int k = 0; k < L; k++) begin
            wr_addr[k*AW +: AW] = 6'd21;
            wr_data[k*DW +: DW] = 32'hC0DE_0000 + 32'(k);
        end
        rs_addr[0 +: AW] = 6'd21;
        rt_addr[2*AW +: AW] = 6'd21;
        #1;
        chk("R7", rs_data[0 +: DW], 32'hC0DE_0003);
        chk("R7", rt_data[2*DW +: DW], 32'hC0DE_0003);
        @(posedge clk);
        model[21] = 32'hC0DE_0003;

        // R6: lanes 0 and 2 collide, lanes 1 and 3 off
        @(negedge clk);
        idle();
        wr_en = 4'b0101;
        for (int k = 0; k < L; k++) begin
            wr_addr[k*AW +: AW] = 6'd40;
            wr_data[k*DW +: DW] = 32'hBEEF_0000 + 32'(k);
        end
        @(posedge clk);
        model[40] = 32'hBEEF_0002;
        @(negedge clk);
        idle();
        rs_addr[0 +: AW] = 6'd21;
        rs_addr[AW +: AW] = 6'd40;
        #1;
        chk("R6", rs_data[0 +: DW], model[21]);
        chk("R6", rs_data[DW +: DW], model[40]);

        // R7: forward on one lane while the neighbour reads stored data
        @(negedge clk);
        idle();
        wr_en = 4'b0010;
        wr_addr[AW +: AW] = 6'd9;
        wr_data[DW +: DW] = 32'h1234_5678;
        rs_addr[2*AW +: AW] = 6'd9;
        rs_addr[3*AW +: AW] = 6'd10;
        #1;
        chk("R7", rs_data[2*DW +: DW], 32'h1234_5678);
        chk("R7", rs_data[3*DW +: DW], model[10]);
        @(posedge clk);
        model[9] = 32'h1234_5678;
        scalar_sweep("R4");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired got running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule